// File: doc/BRIEF.md
# Four-Stage Compact-Instruction Integer Core

This block is a single-issue integer processor with a 32-bit datapath and 16-bit instructions. Each instruction moves through four stages: fetch, register read, execute and writeback. Sixteen 32-bit registers sit behind two read ports and one write port. Register 0 always reads as zero. Results reach dependent instructions without stalls by two routes. The first forwards the writeback-stage result into the execute operands. The second passes the value being written through the register file to a same-cycle reader. The ALU can add, subtract, AND, OR and XOR. It can also shift left or logically right by one or four bit positions. A multiplexer selects an immediate operand in place of the second register when the instruction needs one.

Instructions are read through a halfword fetch port: the core drives a byte address and expects the instruction on the same cycle. Branches are resolved in execute. They can be PC-relative conditional, PC-relative unconditional, jump-and-link, or jump to a register. A taken branch discards the two younger instructions. Loads and stores go out in writeback through a request/ready data port, using an address register. The whole pipeline holds until the port signals ready.

A small control machine sequences the pipeline. ST_BOOT lasts one cycle after reset, with fetch disabled, and always moves to ST_RUN. ST_RUN moves to ST_MEMWAIT when a memory access in writeback is not yet acknowledged. ST_MEMWAIT returns to ST_RUN in the cycle that ready is seen.

Top module: `hw16_core`

## Requirements
- R1: While reset is held, imem_addr equals RESET_PC (0) and dmem_req is low. The first fetch after release is at RESET_PC, and later fetches are at RESET_PC+2, +4 and so on.
- R2: Register instructions use the fields op[15:12], rd[11:8], ra[7:4] and rb[3:0]. They compute rd = ra op rb, where op 0 is ADD, 1 is SUB (ra-rb), 2 is AND, 3 is OR and 4 is XOR.
- R3: ADDI (op 5) writes ra + sign-extended bits [3:0] into rd. LDI (op 7) writes sign-extended bits [7:0] into rd.
- R4: SHF (op 6) writes ra shifted into rd. Bits [1:0] select the shift: 0 is left by 1, 1 is left by 4, 2 is logical right by 1, and 3 is logical right by 4.
- R5: Register 0 reads as zero in every case, including just after an instruction that names it as destination. Writes to it have no effect.
- R6: A result is usable by the next instruction and by the one after it, with no stall.
- R7: BEQZ (op 10) branches when register [11:8] is zero. BNEZ (op 11) branches when it is nonzero. The target is the branch address + 2 + 2 × sign-extended bits [7:0].
- R8: BR (op 12) always branches to its address + 2 + 2 × sign-extended bits [11:0]. Any taken branch or jump discards the two younger instructions.
- R9: JAL (op 13) writes its own address + 2 into rd and branches to its address + 2 + 2 × sign-extended bits [7:0]. JR (op 14) jumps to the value of ra.
- R10: LW (op 8) loads rd, and SW (op 9) stores the register named in [11:8]. Both use the byte address ra + 4 × zero-extended bits [3:0]. Op 15 does nothing.
- R11: While dmem_req is high and dmem_ready is low, the request, its address, its write flag, its data and imem_addr all stay unchanged. A loaded value is usable by the next instruction.
- R12: With no branch and no stall, imem_addr advances by 2 each cycle and is always even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Fetch byte address |
| imem_data | input | 16 | Instruction at imem_addr, same cycle |
| dmem_req | output | 1 | Data access request |
| dmem_we | output | 1 | Request is a store |
| dmem_addr | output | 32 | Data byte address (address register) |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data, valid when dmem_ready |
| dmem_ready | input | 1 | Access completes this cycle |

## Verification
Architectural state can only be seen through the store stream and the fetch address. The bench therefore has every program store its results and then park on a branch to itself. A register file or forwarding fault shows up as a wrong stored word, typically within the next instruction or two. A flush or target fault shows up as a skipped instruction that still leaves its mark in memory, or as a stray fetch address in the cycle right after the branch leaves execute. A control-state fault in the memory handshake shows up in the first stalled cycle, because the request or the fetch address changes before ready.

// File: rtl/hw16_core_pkg.sv
package hw16_core_pkg;

    localparam int WORD_W = 32;
    localparam int INSN_W = 16;
    localparam int RIDX_W = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_ADDI = 4'd5,
        OP_SHF  = 4'd6,
        OP_LDI  = 4'd7,
        OP_LW   = 4'd8,
        OP_SW   = 4'd9,
        OP_BEQZ = 4'd10,
        OP_BNEZ = 4'd11,
        OP_BR   = 4'd12,
        OP_JAL  = 4'd13,
        OP_JR   = 4'd14,
        OP_NOP  = 4'd15
    } opcode_e;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_SHL1, ALU_SHL4, ALU_SHR1, ALU_SHR4, ALU_PASSB
    } alu_op_e;

    typedef enum logic [2:0] {
        FL_NONE, FL_EQZ, FL_NEZ, FL_ALWAYS, FL_REG
    } flow_e;

    typedef enum logic [1:0] {
        ST_BOOT, ST_RUN, ST_MEMWAIT
    } pstate_e;

    typedef struct packed {
        alu_op_e             alu;
        logic                use_imm;
        logic [WORD_W-1:0]   imm;
        logic                wr;
        logic [RIDX_W-1:0]   rd;
        logic [RIDX_W-1:0]   rs_a;
        logic [RIDX_W-1:0]   rs_b;
        logic                ld;
        logic                st;
        logic                link;
        flow_e               flow;
    } ctrl_t;

endpackage

// File: rtl/hw16_regfile.sv
module hw16_regfile #(
    parameter int W    = 32,
    parameter int AW   = 4,
    parameter int NRD  = 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [W-1:0]      wdata,
    input  logic [NRD*AW-1:0] raddr,
    output logic [NRD*W-1:0]  rdata
);
    localparam int NREG = 1 << AW;

    logic [W-1:0] regs [1:NREG-1];

    always_ff @(posedge clk) begin
        for (int i = 1; i < NREG; i++) begin
            if (we && waddr == AW'(i)) begin
                regs[i] <= wdata;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [AW-1:0] ra;
        assign ra = raddr[p*AW +: AW];
        always_comb begin
            if (ra == '0) begin
                rdata[p*W +: W] = '0;
            end else if (we && waddr == ra) begin
                rdata[p*W +: W] = wdata;
            end else begin
                rdata[p*W +: W] = regs[ra];
            end
        end
    end

endmodule

// File: rtl/hw16_decode.sv
module hw16_decode
    import hw16_core_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int IW = INSN_W
) (
    input  logic [IW-1:0] ir,
    output ctrl_t         ctrl
);
    opcode_e op;
    assign op = opcode_e'(ir[IW-1 -: 4]);

    always_comb begin
        ctrl         = '0;
        ctrl.alu     = ALU_ADD;
        ctrl.flow    = FL_NONE;
        ctrl.rd      = ir[11:8];
        ctrl.rs_a    = ir[7:4];
        ctrl.rs_b    = ir[3:0];
        unique case (op)
            OP_ADD:  begin ctrl.alu = ALU_ADD; ctrl.wr = 1'b1; end
            OP_SUB:  begin ctrl.alu = ALU_SUB; ctrl.wr = 1'b1; end
            OP_AND:  begin ctrl.alu = ALU_AND; ctrl.wr = 1'b1; end
            OP_OR:   begin ctrl.alu = ALU_OR;  ctrl.wr = 1'b1; end
            OP_XOR:  begin ctrl.alu = ALU_XOR; ctrl.wr = 1'b1; end
            OP_ADDI: begin
                ctrl.alu     = ALU_ADD;
                ctrl.use_imm = 1'b1;
                ctrl.imm     = W'(signed'(ir[3:0]));
                ctrl.wr      = 1'b1;
            end
            OP_SHF: begin
                unique case (ir[1:0])
                    2'd0: ctrl.alu = ALU_SHL1;
                    2'd1: ctrl.alu = ALU_SHL4;
                    2'd2: ctrl.alu = ALU_SHR1;
                    default: ctrl.alu = ALU_SHR4;
                endcase
                ctrl.wr = 1'b1;
            end
            OP_LDI: begin
                ctrl.alu     = ALU_PASSB;
                ctrl.use_imm = 1'b1;
                ctrl.imm     = W'(signed'(ir[7:0]));
                ctrl.wr      = 1'b1;
            end
            OP_LW: begin
                ctrl.use_imm = 1'b1;
                ctrl.imm     = W'({ir[3:0], 2'b00});
                ctrl.wr      = 1'b1;
                ctrl.ld      = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.imm     = W'({ir[3:0], 2'b00});
                ctrl.rs_b    = ir[11:8];
                ctrl.st      = 1'b1;
            end
            OP_BEQZ, OP_BNEZ: begin
                ctrl.rs_a = ir[11:8];
                ctrl.imm  = W'(signed'({ir[7:0], 1'b0}));
                ctrl.flow = (op == OP_BEQZ) ? FL_EQZ : FL_NEZ;
            end
            OP_BR: begin
                ctrl.imm  = W'(signed'({ir[11:0], 1'b0}));
                ctrl.flow = FL_ALWAYS;
            end
            OP_JAL: begin
                ctrl.imm  = W'(signed'({ir[7:0], 1'b0}));
                ctrl.flow = FL_ALWAYS;
                ctrl.link = 1'b1;
                ctrl.wr   = 1'b1;
            end
            OP_JR: begin
                ctrl.flow = FL_REG;
            end
            default: begin
            end
        endcase
        if (ctrl.rd == '0) begin
            ctrl.wr = 1'b0;
        end
    end

endmodule

// File: rtl/hw16_alu.sv
module hw16_alu
    import hw16_core_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_SHL1: y = a << 1;
            ALU_SHL4: y = a << 4;
            ALU_SHR1: y = a >> 1;
            ALU_SHR4: y = a >> 4;
            default:  y = b;
        endcase
    end

endmodule

// File: rtl/hw16_core.sv
module hw16_core
    import hw16_core_pkg::*;
#(
    parameter int          W        = WORD_W,
    parameter int          IW       = INSN_W,
    parameter int          AW       = RIDX_W,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic          clk,
    input  logic          rst,
    output logic [W-1:0]  imem_addr,
    input  logic [IW-1:0] imem_data,
    output logic          dmem_req,
    output logic          dmem_we,
    output logic [W-1:0]  dmem_addr,
    output logic [W-1:0]  dmem_wdata,
    input  logic [W-1:0]  dmem_rdata,
    input  logic          dmem_ready
);
    localparam int          NRD     = 2;
    localparam logic [W-1:0] PC_STEP = W'(IW / 8);

    pstate_e state, state_nx;
    logic    fetch_en, stall, redirect;
    logic [W-1:0] redirect_pc;

    // fetch
    logic [W-1:0]  pc_q;
    // register read
    logic          rf_valid;
    logic [IW-1:0] rf_ir;
    logic [W-1:0]  rf_pc;
    ctrl_t         rf_ctrl;
    logic [NRD*W-1:0] rf_rdata;
    // execute
    logic          ex_valid;
    ctrl_t         ex_ctrl;
    logic [W-1:0]  ex_pc, ex_a, ex_b;
    logic [W-1:0]  opa, opb, alu_b, alu_y, seq_pc, ex_result;
    logic          taken;
    // writeback
    logic          wb_valid, wb_wr, wb_ld, wb_st;
    logic [AW-1:0] wb_rd;
    logic [W-1:0]  wb_res, wb_sdata, wb_value;
    logic          rf_we;

    // control state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_BOOT;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT:    state_nx = ST_RUN;
            ST_RUN:     if (stall) state_nx = ST_MEMWAIT;
            ST_MEMWAIT: if (dmem_ready) state_nx = ST_RUN;
            default:    state_nx = ST_BOOT;
        endcase
    end

    // control outputs
    always_comb begin
        fetch_en = (state != ST_BOOT);
        stall    = wb_valid && (wb_ld || wb_st) && !dmem_ready;
    end

    // fetch stage
    assign imem_addr = pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= RESET_PC;
            rf_valid <= 1'b0;
            rf_ir    <= '0;
            rf_pc    <= '0;
        end else if (!fetch_en) begin
            rf_valid <= 1'b0;
        end else if (!stall) begin
            pc_q     <= redirect ? redirect_pc : pc_q + PC_STEP;
            rf_valid <= !redirect;
            rf_ir    <= imem_data;
            rf_pc    <= pc_q;
        end
    end

    // register read stage
    hw16_decode #(.W(W), .IW(IW)) u_dec (
        .ir   (rf_ir),
        .ctrl (rf_ctrl)
    );

    hw16_regfile #(.W(W), .AW(AW), .NRD(NRD)) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .waddr (wb_rd),
        .wdata (wb_value),
        .raddr ({rf_ctrl.rs_b, rf_ctrl.rs_a}),
        .rdata (rf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_valid <= 1'b0;
            ex_ctrl  <= '0;
            ex_pc    <= '0;
            ex_a     <= '0;
            ex_b     <= '0;
        end else if (!stall) begin
            ex_valid <= rf_valid && !redirect;
            ex_ctrl  <= rf_ctrl;
            ex_pc    <= rf_pc;
            ex_a     <= rf_rdata[0 +: W];
            ex_b     <= rf_rdata[W +: W];
        end
    end

    // execute stage: result forwarding from writeback
    always_comb begin
        opa = ex_a;
        opb = ex_b;
        if (wb_valid && wb_wr && wb_rd == ex_ctrl.rs_a) opa = wb_value;
        if (wb_valid && wb_wr && wb_rd == ex_ctrl.rs_b) opb = wb_value;
    end

    assign alu_b = ex_ctrl.use_imm ? ex_ctrl.imm : opb;

    hw16_alu #(.W(W)) u_alu (
        .op (ex_ctrl.alu),
        .a  (opa),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign seq_pc    = ex_pc + PC_STEP;
    assign ex_result = ex_ctrl.link ? seq_pc : alu_y;

    always_comb begin
        unique case (ex_ctrl.flow)
            FL_EQZ:    taken = (opa == '0);
            FL_NEZ:    taken = (opa != '0);
            FL_ALWAYS: taken = 1'b1;
            FL_REG:    taken = 1'b1;
            default:   taken = 1'b0;
        endcase
        taken       = taken && ex_valid;
        redirect    = taken && !stall;
        redirect_pc = (ex_ctrl.flow == FL_REG) ? {opa[W-1:1], 1'b0}
                                               : seq_pc + ex_ctrl.imm;
    end

    // writeback stage; wb_res doubles as the data address register
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_wr    <= 1'b0;
            wb_ld    <= 1'b0;
            wb_st    <= 1'b0;
            wb_rd    <= '0;
            wb_res   <= '0;
            wb_sdata <= '0;
        end else if (!stall) begin
            wb_valid <= ex_valid;
            wb_wr    <= ex_ctrl.wr;
            wb_ld    <= ex_ctrl.ld;
            wb_st    <= ex_ctrl.st;
            wb_rd    <= ex_ctrl.rd;
            wb_res   <= ex_result;
            wb_sdata <= opb;
        end
    end

    assign wb_value   = wb_ld ? dmem_rdata : wb_res;
    assign rf_we      = wb_valid && wb_wr && !stall;
    assign dmem_req   = wb_valid && (wb_ld || wb_st);
    assign dmem_we    = wb_st;
    assign dmem_addr  = wb_res;
    assign dmem_wdata = wb_sdata;

endmodule

// File: rtl/hw16_core_chk.sv
module hw16_core_chk
    import hw16_core_pkg::*;
#(
    parameter int W = WORD_W
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] imem_addr,
    input logic         dmem_req,
    input logic         dmem_we,
    input logic [W-1:0] dmem_addr,
    input logic [W-1:0] dmem_wdata,
    input logic         dmem_ready,
    input logic         stall,
    input logic         redirect,
    input logic [W-1:0] redirect_pc,
    input logic         rf_valid,
    input logic         ex_valid,
    input pstate_e      state
);
    p_even_fetch_r12: assert property (@(posedge clk) disable iff (rst)
        imem_addr[0] == 1'b0);

    p_seq_fetch_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !stall && !redirect) |=> imem_addr == $past(imem_addr) + W'(2));

    p_target_r8: assert property (@(posedge clk) disable iff (rst)
        redirect |=> imem_addr == $past(redirect_pc));

    p_flush_r8: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (!rf_valid && !ex_valid));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (dmem_req && !dmem_ready) |=> (dmem_req && $stable(dmem_addr) && $stable(dmem_we)
                                       && $stable(imem_addr)));

    p_wdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (dmem_req && dmem_we && !dmem_ready) |=> $stable(dmem_wdata));

    p_wait_has_req_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MEMWAIT) |-> dmem_req);

endmodule

bind hw16_core hw16_core_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .imem_addr   (imem_addr),
    .dmem_req    (dmem_req),
    .dmem_we     (dmem_we),
    .dmem_addr   (dmem_addr),
    .dmem_wdata  (dmem_wdata),
    .dmem_ready  (dmem_ready),
    .stall       (stall),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .rf_valid    (rf_valid),
    .ex_valid    (ex_valid),
    .state       (state)
);

// File: tb/hw16_core_tb.sv
module hw16_core_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr;
    logic [15:0] imem_data;
    logic        dmem_req, dmem_we, dmem_ready;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;

    logic [15:0] imem [64];
    logic [31:0] dmem [64];
    int          lat = 0;
    int          wcnt = 0;
    int          total = 0;
    int          bad = 0;
    int          cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hw16_core u_dut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .dmem_ready(dmem_ready)
    );

    assign imem_data  = imem[imem_addr[6:1]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    assign dmem_ready = dmem_req && (wcnt >= lat);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (dmem_req && dmem_ready) begin
            wcnt <= 0;
            if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
        end else if (dmem_req) begin
            wcnt <= wcnt + 1;
        end else begin
            wcnt <= 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input int op, input int rd, input int ra, input int rb);
        return {op[3:0], rd[3:0], ra[3:0], rb[3:0]};
    endfunction

    function automatic logic [15:0] ldi(input int rd, input int imm8);
        return {4'h7, rd[3:0], imm8[7:0]};
    endfunction

    function automatic logic [15:0] br_self();
        return 16'hCFFF;
    endfunction

    task automatic clear_mems();
        for (int i = 0; i < 64; i++) begin
            imem[i] = 16'hF000;
            dmem[i] = 32'hDEADBEEF;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_fetch();
        clear_mems();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset imem_addr", imem_addr, 32'h0);
        chk("R1 reset dmem_req", {31'b0, dmem_req}, 32'h0);
        rst = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk("R12 sequential fetch", imem_addr, 32'(2 * (k - 1)));
        end
    endtask

    task automatic t_alu();
        clear_mems();
        lat = 1;
        imem[0]  = ldi(1, 8'h05);
        imem[1]  = ldi(2, 8'hFD);
        imem[2]  = ins(0, 3, 1, 2);
        imem[3]  = ins(1, 4, 1, 2);
        imem[4]  = ins(2, 5, 1, 2);
        imem[5]  = ins(3, 6, 1, 2);
        imem[6]  = ins(4, 7, 1, 2);
        imem[7]  = ins(9, 3, 0, 0);
        imem[8]  = ins(9, 4, 0, 1);
        imem[9]  = ins(9, 5, 0, 2);
        imem[10] = ins(9, 6, 0, 3);
        imem[11] = ins(9, 7, 0, 4);
        imem[12] = br_self();
        do_reset();
        run(60);
        chk("R2 R6 add", dmem[0], 32'd2);
        chk("R2 R6 sub", dmem[1], 32'd8);
        chk("R2 and", dmem[2], 32'd5);
        chk("R2 or", dmem[3], 32'hFFFFFFFD);
        chk("R2 xor", dmem[4], 32'hFFFFFFF8);
    endtask

    task automatic t_imm_shift();
        clear_mems();
        lat = 0;
        imem[0]  = ldi(1, 8'h81);
        imem[1]  = ins(5, 2, 1, 15);
        imem[2]  = ins(6, 3, 1, 0);
        imem[3]  = ins(6, 4, 1, 1);
        imem[4]  = ins(6, 5, 1, 2);
        imem[5]  = ins(6, 6, 1, 3);
        imem[6]  = ins(5, 7, 1, 3);
        imem[7]  = ins(9, 2, 0, 0);
        imem[8]  = ins(9, 3, 0, 1);
        imem[9]  = ins(9, 4, 0, 2);
        imem[10] = ins(9, 5, 0, 3);
        imem[11] = ins(9, 6, 0, 4);
        imem[12] = ins(9, 7, 0, 5);
        imem[13] = br_self();
        do_reset();
        run(50);
        chk("R3 addi negative", dmem[0], 32'hFFFFFF80);
        chk("R4 shl1", dmem[1], 32'hFFFFFF02);
        chk("R4 shl4", dmem[2], 32'hFFFFF810);
        chk("R4 shr1", dmem[3], 32'h7FFFFFC0);
        chk("R4 shr4", dmem[4], 32'h0FFFFFF8);
        chk("R3 addi positive", dmem[5], 32'hFFFFFF84);
    endtask

    task automatic t_r0();
        clear_mems();
        lat = 0;
        imem[0] = ldi(0, 8'h07);
        imem[1] = ins(5, 0, 0, 5);
        imem[2] = ins(9, 0, 0, 0);
        imem[3] = ldi(1, 8'h09);
        imem[4] = ins(0, 2, 0, 1);
        imem[5] = ins(9, 2, 0, 1);
        imem[6] = br_self();
        do_reset();
        run(40);
        chk("R5 r0 stays zero", dmem[0], 32'h0);
        chk("R5 r0 read after write attempt", dmem[1], 32'd9);
    endtask

    task automatic t_branch();
        clear_mems();
        lat = 0;
        imem[0]  = ldi(2, 8'h01);
        imem[1]  = ldi(1, 8'h00);
        imem[2]  = {4'hA, 4'd1, 8'h01};
        imem[3]  = ldi(2, 8'h09);
        imem[4]  = {4'hB, 4'd1, 8'h01};
        imem[5]  = ldi(3, 8'h03);
        imem[6]  = {4'hB, 4'd2, 8'h01};
        imem[7]  = ldi(3, 8'h09);
        imem[8]  = ins(9, 2, 0, 0);
        imem[9]  = ins(9, 3, 0, 1);
        imem[10] = br_self();
        do_reset();
        run(50);
        chk("R7 beqz taken skips", dmem[0], 32'd1);
        chk("R7 bnez fallthrough and taken", dmem[1], 32'd3);
    endtask

    task automatic t_jump();
        clear_mems();
        lat = 0;
        imem[0] = ldi(5, 8'd24);
        imem[1] = ldi(7, 8'h01);
        imem[2] = {4'hD, 4'd6, 8'h02};
        imem[3] = ldi(7, 8'h09);
        imem[4] = ldi(7, 8'h09);
        imem[5] = ins(9, 6, 0, 0);
        imem[6] = ins(14, 0, 5, 0);
        for (int i = 7; i < 12; i++) imem[i] = ldi(7, 8'h09);
        imem[12] = ins(9, 7, 0, 1);
        imem[13] = br_self();
        do_reset();
        run(50);
        chk("R9 jal link", dmem[0], 32'd6);
        chk("R8 R9 shadow flushed and jr target", dmem[1], 32'd1);
    endtask

    task automatic t_mem();
        logic        seen;
        logic [31:0] first_addr;
        logic        first_we;
        logic        hold;
        logic [31:0] hold_pc;
        logic [31:0] hold_addr;
        int          waits;
        int          viol;
        clear_mems();
        lat = 3;
        dmem[2] = 32'h12345678;
        imem[0] = ldi(1, 8'h08);
        imem[1] = ins(8, 2, 0, 2);
        imem[2] = ins(5, 3, 2, 1);
        imem[3] = ins(9, 3, 0, 3);
        imem[4] = ins(9, 2, 1, 2);
        imem[5] = br_self();
        seen = 1'b0; first_addr = '0; first_we = 1'b0;
        hold = 1'b0; hold_pc = '0; hold_addr = '0;
        waits = 0; viol = 0;
        do_reset();
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            if (hold && (imem_addr !== hold_pc || dmem_addr !== hold_addr || !dmem_req)) viol++;
            if (dmem_req && !seen) begin
                seen = 1'b1;
                first_addr = dmem_addr;
                first_we = dmem_we;
            end
            hold = dmem_req && !dmem_ready;
            hold_pc = imem_addr;
            hold_addr = dmem_addr;
            if (hold) waits++;
        end
        chk("R10 load address", first_addr, 32'd8);
        chk("R10 load is read", {31'b0, first_we}, 32'h0);
        chk("R11 held while not ready", 32'(viol), 32'h0);
        chk("R11 stall cycles seen", 32'(waits >= 9), 32'h1);
        chk("R11 load-use result", dmem[3], 32'h12345679);
        chk("R10 store base plus offset", dmem[4], 32'h12345678);
    endtask

    initial begin
        t_reset_fetch();
        t_alu();
        t_imm_shift();
        t_r0();
        t_branch();
        t_jump();
        t_mem();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule